// File: doc/BRIEF.md
# External Trigger Capture and Counter-Reset Unit

This block sits beside a free-running 24-bit timer counter and watches one external trigger pin. The pin is first brought into the clock domain by a two-flop synchroniser. It can then go through an optional de-bounce filter before edges are detected. A 2-bit edge field picks which transitions qualify. When the pin is enabled, each qualifying edge does one of two things, chosen by a mode bit: it latches the current counter value into a capture register, or it raises a one-cycle request that the counter clears itself.

In capture mode a qualifying edge also sets an external-event flag. Software clears this flag by pulsing a clear strobe, which stands for a write of 1 to the flag. An interrupt output follows the flag gated by its own enable bit. The bus interface and the counter itself live outside this block. All outputs are registered.

Top module: `ext_trig_unit`

## Requirements
- R1: While `rst` is high and on the first clock after it, `cap_val`, `cnt_rst_req`, `ext_flag` and `ext_irq` are all 0.
- R2: With de-bounce off, a pin change driven between clock edges shows its effect on the outputs at the third rising edge after the change. The first two edges fill the synchroniser.
- R3: Edge code 2'b00 qualifies only high-to-low transitions of the filtered pin.
- R4: Edge code 2'b01 qualifies only low-to-high transitions of the filtered pin.
- R5: Edge code 2'b10 qualifies transitions in both directions.
- R6: Edge code 2'b11 qualifies no transition.
- R7: While `pin_en` is 0, pin transitions have no effect. The flag, the capture value and the reset request all stay as they are.
- R8: With `rst_sel` at 0, a qualifying edge loads the `cnt_val` seen at that edge into `cap_val` and sets `ext_flag`.
- R9: With `rst_sel` at 1, a qualifying edge pulses `cnt_rst_req` high for exactly one cycle. It does not change `cap_val` and does not set `ext_flag`.
- R10: A one-cycle `flag_clr` pulse clears `ext_flag` at the next clock edge.
- R11: If a capture event and `flag_clr` fall in the same cycle, the flag ends up set.
- R12: `ext_irq` equals `ext_flag` AND `irq_en`, both taken at the same clock edge. It falls on the edge after `irq_en` drops.
- R13: With `db_en` at 1, edges are taken from a filtered level that changes only after the synchronised pin has differed from it on 3 consecutive clocks. A pulse of 2 clocks is dropped. A settled rise shows on the outputs at the sixth rising edge after the pin change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_val | input | 24 | Current value of the timer counter |
| trig_pin | input | 1 | Asynchronous external trigger pin |
| pin_en | input | 1 | Enables edge actions from the pin |
| rst_sel | input | 1 | 0: capture on edge, 1: counter-reset request on edge |
| edge_sel | input | 2 | Edge code: 00 fall, 01 rise, 10 both, 11 none |
| db_en | input | 1 | Takes edges from the de-bounced level |
| irq_en | input | 1 | External interrupt enable |
| flag_clr | input | 1 | Clear strobe for the external flag (write-1 pulse) |
| cap_val | output | 24 | Captured counter value |
| cnt_rst_req | output | 1 | One-cycle request to clear the counter |
| ext_flag | output | 1 | External event flag |
| ext_irq | output | 1 | External interrupt |

## Verification
The bench checks edge latency exactly: a synchroniser that is one flop short or one flop long moves the flag by one cycle, and the per-cycle model reports that. Each edge code is driven in both pin directions. This catches a swapped encoding, and it also catches code 11 wrongly treated as "both". A 2-clock glitch under de-bounce would set the flag if the filter threshold were off by one. Holding the clear strobe across a capture shows a design where the clear beats the set, because such a design never raises the flag. Reset mode is checked for a request that lasts longer than one cycle and for a stray capture or flag.

// File: rtl/trig_pkg.sv
package trig_pkg;
  typedef enum logic [1:0] {
    EDGE_FALL = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_NONE = 2'b11
  } edge_mode_e;
endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/trig_debounce.sv
module trig_debounce #(
  parameter int LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic lvl_q
);
  localparam int CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= 1'b0;
      run_q <= '0;
    end else if (din == lvl_q) begin
      run_q <= '0;
    end else if (run_q == LAST) begin
      lvl_q <= din;
      run_q <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  // R13
  db_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(lvl_q) |-> (lvl_q == $past(din)));

  // R13
  db_run_bound_chk: assert property (@(posedge clk) disable iff (rst)
    run_q <= LAST);
endmodule

// File: rtl/trig_edge.sv
module trig_edge
  import trig_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       lvl,
  input  logic [1:0] edge_sel,
  output logic       hit
);
  logic prev_q;
  logic rose, fell;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl;
  end

  assign rose = lvl & ~prev_q;
  assign fell = ~lvl & prev_q;

  always_comb begin
    unique case (edge_mode_e'(edge_sel))
      EDGE_FALL: hit = fell;
      EDGE_RISE: hit = rose;
      EDGE_BOTH: hit = rose | fell;
      default:   hit = 1'b0;
    endcase
  end

  // R6
  none_code_chk: assert property (@(posedge clk) disable iff (rst)
    (edge_sel == 2'b11) |-> !hit);
endmodule

// File: rtl/ext_trig_unit.sv
module ext_trig_unit #(
  parameter int CNT_W       = 24,
  parameter int SYNC_STAGES = 2,
  parameter int DB_LEN      = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             trig_pin,
  input  logic             pin_en,
  input  logic             rst_sel,
  input  logic [1:0]       edge_sel,
  input  logic             db_en,
  input  logic             irq_en,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cap_val,
  output logic             cnt_rst_req,
  output logic             ext_flag,
  output logic             ext_irq
);
  logic pin_s, pin_db, pin_lvl, edge_hit;
  logic cap_hit, rst_hit, flag_nx;

  trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(trig_pin), .dout(pin_s)
  );

  trig_debounce #(.LEN(DB_LEN)) u_db (
    .clk(clk), .rst(rst), .din(pin_s), .lvl_q(pin_db)
  );

  assign pin_lvl = db_en ? pin_db : pin_s;

  trig_edge u_edge (
    .clk(clk), .rst(rst), .lvl(pin_lvl), .edge_sel(edge_sel), .hit(edge_hit)
  );

  assign cap_hit = pin_en & edge_hit & ~rst_sel;
  assign rst_hit = pin_en & edge_hit & rst_sel;
  assign flag_nx = cap_hit | (ext_flag & ~flag_clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_val     <= '0;
      cnt_rst_req <= 1'b0;
      ext_flag    <= 1'b0;
      ext_irq     <= 1'b0;
    end else begin
      if (cap_hit) cap_val <= cnt_val;
      cnt_rst_req <= rst_hit;
      ext_flag    <= flag_nx;
      ext_irq     <= flag_nx & irq_en;
    end
  end

  // R7
  pin_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (!pin_en && !ext_flag) |=> (!ext_flag && !cnt_rst_req));

  // R9
  rst_mode_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_rst_req |-> ($past(rst_sel) && $stable(cap_val)));

  // R11
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    cap_hit |=> ext_flag);

  // R10
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && !cap_hit) |=> !ext_flag);

  // R12
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    ext_irq |-> ext_flag);
endmodule

// File: tb/test_ext_trig_unit.sv
module test_ext_trig_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] cnt_val = '0;
  logic        trig_pin = 1'b0;
  logic        pin_en = 1'b0, rst_sel = 1'b0, db_en = 1'b0, irq_en = 1'b0, flag_clr = 1'b0;
  logic [1:0]  edge_sel = 2'b00;
  logic [23:0] cap_val;
  logic        cnt_rst_req, ext_flag, ext_irq;

  int total = 0, bad = 0;
  string cur_req = "R1";
  bit started = 0;

  // reference model state
  logic m_s1, m_s2, m_db, m_prev, m_req, m_flag, m_irq;
  int m_run;
  logic [23:0] m_cap;

  always #10 clk = ~clk;

  ext_trig_unit i_ext_trig_unit (
    .clk(clk), .rst(rst), .cnt_val(cnt_val), .trig_pin(trig_pin),
    .pin_en(pin_en), .rst_sel(rst_sel), .edge_sel(edge_sel), .db_en(db_en),
    .irq_en(irq_en), .flag_clr(flag_clr), .cap_val(cap_val),
    .cnt_rst_req(cnt_rst_req), .ext_flag(ext_flag), .ext_irq(ext_irq)
  );

  always @(negedge clk) cnt_val <= cnt_val + 24'd7;

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", r, act, exp, $time);
    end
  endtask

  // behavioural reference, evaluated on every rising edge
  always @(posedge clk) begin
    logic lvl, up, down, qual, ev_cap, ev_rst, old_s2;
    started = 1;
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_db = 0; m_run = 0; m_prev = 0;
      m_cap = 0; m_req = 0; m_flag = 0; m_irq = 0;
    end else begin
      old_s2 = m_s2;
      lvl  = db_en ? m_db : old_s2;
      up   = lvl && !m_prev;
      down = !lvl && m_prev;
      case (edge_sel)
        2'b00: qual = down;
        2'b01: qual = up;
        2'b10: qual = up || down;
        default: qual = 0;
      endcase
      ev_cap = pin_en && qual && !rst_sel;
      ev_rst = pin_en && qual && rst_sel;
      m_prev = lvl;
      if (old_s2 == m_db) m_run = 0;
      else if (m_run == 2) begin m_db = old_s2; m_run = 0; end
      else m_run = m_run + 1;
      m_s2 = m_s1;
      m_s1 = trig_pin;
      if (ev_cap) m_cap = cnt_val;
      m_req  = ev_rst;
      m_flag = ev_cap ? 1'b1 : (flag_clr ? 1'b0 : m_flag);
      m_irq  = m_flag && irq_en;
    end
  end

  // per-cycle comparison, away from the rising edge
  always @(negedge clk) begin
    if (started) begin
      chk({cur_req, " cap"},  cap_val,     m_cap);
      chk({cur_req, " req"},  cnt_rst_req, m_req);
      chk({cur_req, " flag"}, ext_flag,    m_flag);
      chk({cur_req, " irq"},  ext_irq,     m_irq);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_flag();
    flag_clr = 1; tick(1); flag_clr = 0;
  endtask

  initial begin
    #(20 * 20000);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(3);
    chk("R1 reset cap", cap_val, 0);
    chk("R1 reset flag", ext_flag, 0);
    rst = 0;
    tick(1);
    chk("R1 post-reset req", cnt_rst_req, 0);
    chk("R1 post-reset irq", ext_irq, 0);

    cur_req = "R4"; pin_en = 1; edge_sel = 2'b01; tick(2);
    trig_pin = 1; tick(2);
    chk("R2 latency not yet", ext_flag, 0);
    tick(1);
    chk("R4 rise sets flag", ext_flag, 1);
    chk("R8 capture nonzero", (cap_val != 0), 1);
    cur_req = "R10"; clear_flag();
    chk("R10 flag cleared", ext_flag, 0);

    cur_req = "R3"; edge_sel = 2'b00;
    trig_pin = 0; tick(4);
    chk("R3 fall sets flag", ext_flag, 1);
    clear_flag();
    trig_pin = 1; tick(4);
    chk("R3 rise ignored", ext_flag, 0);

    cur_req = "R5"; edge_sel = 2'b10;
    trig_pin = 0; tick(4);
    chk("R5 fall seen", ext_flag, 1);
    clear_flag();
    trig_pin = 1; tick(4);
    chk("R5 rise seen", ext_flag, 1);
    clear_flag();

    cur_req = "R6"; edge_sel = 2'b11;
    trig_pin = 0; tick(4); trig_pin = 1; tick(4);
    chk("R6 reserved code", ext_flag, 0);

    begin
      logic [23:0] held;
      int reqs;
      cur_req = "R7"; edge_sel = 2'b10; pin_en = 0; held = cap_val; reqs = 0;
      trig_pin = 0; tick(4); trig_pin = 1;
      for (int i = 0; i < 5; i++) begin tick(1); reqs += cnt_rst_req; end
      chk("R7 flag untouched", ext_flag, 0);
      chk("R7 cap untouched", cap_val, held);
      chk("R7 no request", reqs, 0);

      cur_req = "R9"; pin_en = 1; rst_sel = 1; edge_sel = 2'b01;
      trig_pin = 0; tick(4); held = cap_val; reqs = 0;
      trig_pin = 1;
      for (int i = 0; i < 6; i++) begin tick(1); reqs += cnt_rst_req; end
      chk("R9 one-cycle request", reqs, 1);
      chk("R9 no flag", ext_flag, 0);
      chk("R9 cap kept", cap_val, held);
    end

    cur_req = "R12"; rst_sel = 0; irq_en = 1; edge_sel = 2'b10;
    trig_pin = 0; tick(4);
    chk("R12 irq raised", ext_irq, 1);
    irq_en = 0; tick(1);
    chk("R12 irq gated off", ext_irq, 0);
    chk("R12 flag kept", ext_flag, 1);
    clear_flag();

    begin
      int highs = 0;
      cur_req = "R11"; flag_clr = 1; trig_pin = 1;
      for (int i = 0; i < 6; i++) begin tick(1); highs += ext_flag; end
      chk("R11 set beats clear", highs, 1);
      flag_clr = 0;
    end

    cur_req = "R13"; db_en = 1; edge_sel = 2'b01; trig_pin = 0; tick(8);
    trig_pin = 1; tick(2); trig_pin = 0; tick(8);
    chk("R13 glitch dropped", ext_flag, 0);
    trig_pin = 1; tick(5);
    chk("R13 not yet settled", ext_flag, 0);
    tick(1);
    chk("R13 settled edge", ext_flag, 1);
    tick(2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule